// File: doc/BRIEF.md
# Sensor Error Interrupt Aggregator

This block gathers single-cycle error strobes from the limit comparators of a hardware monitor (two fan tachometer counters, five supply voltages, three temperature sensors and a chassis-intrusion switch). It latches them into two 8-bit status words and combines them with two 8-bit mask words into one interrupt line. It also drives a thermal alarm request from the three temperature errors.

Software uses a small register bus to read or write four registers. Reading a status word returns its latched bits and empties that word. The mask words are read/write. When a status word is read, the interrupt line drops for one cycle. It then rises again if enabled errors are still latched, including errors that arrived during the read. This gives a fresh edge for every error left unserviced.

Top module: `hwmon_irq_agg`

## Requirements
- R1: Status word 1 (register address 0) latches each strobe of `evt1_i` into the same bit, whatever the mask. Bit 7 = fan 2 count, bit 6 = fan 1 count, bit 4 = temperature sensor 1, bit 3 = 5 V, bit 2 = internal 3.3 V, bit 1 = 2.5 V, bit 0 = CPU core voltage. A latched bit holds until the word is read.
- R2: Status word 2 (address 1) latches `evt2_i` bit 7 = temperature sensor 3, bit 4 = chassis intrusion, bit 3 = 12 V, bit 0 = temperature sensor 2. Reserved status bits (word 1 bit 5, word 2 bits 6, 5, 2, 1) always read 0, even when strobed.
- R3: A bus read (`bus_rd_i` = 1) of a status address clears every bit of that word at the next clock edge. The other status word is left unchanged.
- R4: A strobe that arrives in the same cycle as a clearing read of its word is still latched after that read.
- R5: All mask bits are 0 after reset. A mask bit of 0 enables the interrupt for the status bit at the same position, and a mask bit of 1 disables it.
- R6: Mask word 1 (address 2) stores all 8 written bits. Mask word 2 (address 3) stores bits 7, 6, 5, 4, 3 and 0, and bits 2:1 read 0. A write to a status address changes nothing. `bus_rdata_o` always shows the register selected by `bus_addr_i`.
- R7: `irq_o` is high when any latched status bit has its mask bit at 0.
- R8: In the cycle after any status read, `irq_o` is low. From the following cycle on, it follows R7 again, so it rises again if enabled errors are still pending or have newly arrived.
- R9: `therm_alarm_o` is high only when `throttle_en_i` is 1 and at least one of these holds: sensor 1 error latched with mask 1 bit 5 = 0, sensor 2 error latched with mask 2 bit 5 = 0, or sensor 3 error latched with mask 2 bit 6 = 0.
- R10: The thermal-alarm mask bits do not enable the interrupt. With all status-position mask bits at 1, `irq_o` stays low even when temperature errors are latched and their alarm mask bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt1_i | input | 8 | Error strobes for status word 1, one per bit position |
| evt2_i | input | 8 | Error strobes for status word 2, one per bit position |
| bus_addr_i | input | 2 | Register select: 0 status 1, 1 status 2, 2 mask 1, 3 mask 2 |
| bus_rd_i | input | 1 | Read strobe; clears a selected status word |
| bus_wr_i | input | 1 | Write strobe for a selected mask word |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Contents of the selected register |
| throttle_en_i | input | 1 | Clock-throttle enable that gates the thermal alarm |
| irq_o | output | 1 | Interrupt request |
| therm_alarm_o | output | 1 | Thermal alarm request |

## Verification
The assertions assume that read and write strobes are never both high in one cycle, that each strobe lasts one cycle per event, and that the strobe inputs do not change between clock edges. The stimulus changes inputs only at the falling edge. It issues one bus operation per cycle and returns every strobe to zero at the next step. It also places a read and a new strobe in the same cycle only on purpose, to exercise R4 and the re-raise of R8.

// File: rtl/hwmon_irq_pkg.sv
package hwmon_irq_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned ADR_W = 2;

  // bits that exist in each register
  localparam logic [REG_W-1:0] STAT1_LIVE = 8'hDF;
  localparam logic [REG_W-1:0] STAT2_LIVE = 8'h99;
  localparam logic [REG_W-1:0] MSK1_LIVE  = 8'hFF;
  localparam logic [REG_W-1:0] MSK2_LIVE  = 8'hF9;

  // temperature error positions in the status words
  localparam int unsigned TS1_STAT_BIT = 4;  // word 1
  localparam int unsigned TS2_STAT_BIT = 0;  // word 2
  localparam int unsigned TS3_STAT_BIT = 7;  // word 2
  // thermal-alarm mask positions
  localparam int unsigned TS1_ALM_BIT  = 5;  // mask 1
  localparam int unsigned TS2_ALM_BIT  = 5;  // mask 2
  localparam int unsigned TS3_ALM_BIT  = 6;  // mask 2

  typedef enum logic [ADR_W-1:0] {
    SEL_STAT1 = 2'd0,
    SEL_STAT2 = 2'd1,
    SEL_MSK1  = 2'd2,
    SEL_MSK2  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/hwmon_stat_word.sv
module hwmon_stat_word #(
  parameter int unsigned    W    = 8,
  parameter logic [W-1:0]   LIVE = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] st_q, st_d, evt_live;
  logic         st_en;

  always_comb begin
    evt_live = evt_i & LIVE;
    st_en    = clr_i | (|evt_live);
    st_d     = (clr_i ? '0 : st_q) | evt_live;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign stat_o = st_q;

  // R4
  evt_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_i & LIVE)) |=> ((stat_o & $past(evt_i & LIVE)) == $past(evt_i & LIVE)));
  // R3
  clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(|(evt_i & LIVE))) |=> (stat_o == '0));
  // R1
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(|evt_i)) |=> $stable(stat_o));
endmodule

// File: rtl/hwmon_mask_reg.sv
module hwmon_mask_reg #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] msk_o
);
  logic [W-1:0] msk_q, msk_d;

  always_comb msk_d = wdata_i & LIVE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   msk_q <= '0;
    else if (wr_i) msk_q <= msk_d;
  end

  assign msk_o = msk_q;

  // R6
  wr_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (msk_o == ($past(wdata_i) & LIVE)));
  // R6
  msk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(msk_o));
endmodule

// File: rtl/hwmon_irq_gen.sv
module hwmon_irq_gen
  import hwmon_irq_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] stat1_i,
  input  logic [W-1:0] stat2_i,
  input  logic [W-1:0] msk1_i,
  input  logic [W-1:0] msk2_i,
  input  logic         rd_stat_i,
  input  logic         throttle_en_i,
  output logic         irq_o,
  output logic         alarm_o
);
  logic gap_q, gap_d;
  logic pend, hot;

  always_comb begin
    gap_d = rd_stat_i;
    pend  = (|(stat1_i & ~msk1_i & W'(STAT1_LIVE))) |
            (|(stat2_i & ~msk2_i & W'(STAT2_LIVE)));
    hot   = (stat1_i[TS1_STAT_BIT] & ~msk1_i[TS1_ALM_BIT]) |
            (stat2_i[TS2_STAT_BIT] & ~msk2_i[TS2_ALM_BIT]) |
            (stat2_i[TS3_STAT_BIT] & ~msk2_i[TS3_ALM_BIT]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= 1'b0;
    else         gap_q <= gap_d;
  end

  assign irq_o   = pend & ~gap_q;
  assign alarm_o = hot & throttle_en_i;

  // R8
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat_i |=> !irq_o);
  // R7
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((|(stat1_i & ~msk1_i)) || (|(stat2_i & ~msk2_i))));
endmodule

// File: rtl/hwmon_irq_agg.sv
module hwmon_irq_agg
  import hwmon_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] evt1_i,
  input  logic [REG_W-1:0] evt2_i,
  input  logic [ADR_W-1:0] bus_addr_i,
  input  logic             bus_rd_i,
  input  logic             bus_wr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  output logic [REG_W-1:0] bus_rdata_o,
  input  logic             throttle_en_i,
  output logic             irq_o,
  output logic             therm_alarm_o
);
  localparam int unsigned NWORD = 2;

  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NWORD-1:0][REG_W-1:0] evt, stat, msk;
  logic [NWORD-1:0]            clr, wr;
  logic                        rd_stat;

  assign evt[0] = evt1_i;
  assign evt[1] = evt2_i;

  always_comb begin
    clr[0]  = bus_rd_i && (bus_addr_i == SEL_STAT1);
    clr[1]  = bus_rd_i && (bus_addr_i == SEL_STAT2);
    wr[0]   = bus_wr_i && (bus_addr_i == SEL_MSK1);
    wr[1]   = bus_wr_i && (bus_addr_i == SEL_MSK2);
    rd_stat = |clr;
  end

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    localparam logic [REG_W-1:0] ST_LIVE = (g == 0) ? STAT1_LIVE : STAT2_LIVE;
    localparam logic [REG_W-1:0] MK_LIVE = (g == 0) ? MSK1_LIVE  : MSK2_LIVE;

    hwmon_stat_word #(.W(REG_W), .LIVE(ST_LIVE)) i_stat (
      .clk_i  (clk_i),
      .rst_ni (rst_sync_q),
      .evt_i  (evt[g]),
      .clr_i  (clr[g]),
      .stat_o (stat[g])
    );

    hwmon_mask_reg #(.W(REG_W), .LIVE(MK_LIVE)) i_msk (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_q),
      .wr_i    (wr[g]),
      .wdata_i (bus_wdata_i),
      .msk_o   (msk[g])
    );
  end

  hwmon_irq_gen #(.W(REG_W)) i_irq (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_q),
    .stat1_i       (stat[0]),
    .stat2_i       (stat[1]),
    .msk1_i        (msk[0]),
    .msk2_i        (msk[1]),
    .rd_stat_i     (rd_stat),
    .throttle_en_i (throttle_en_i),
    .irq_o         (irq_o),
    .alarm_o       (therm_alarm_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      SEL_STAT1: bus_rdata_o = stat[0];
      SEL_STAT2: bus_rdata_o = stat[1];
      SEL_MSK1:  bus_rdata_o = msk[0];
      default:   bus_rdata_o = msk[1];
    endcase
  end
endmodule

// File: tb/test_hwmon_irq_agg.sv
module test_hwmon_irq_agg;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] evt1, evt2, wdata, rdata;
  logic [1:0] addr;
  logic       rd, wr, thr, irq, alarm;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  int m_st1, m_st2, m_mk1, m_mk2;
  bit m_gap;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwmon_irq_agg i_hwmon_irq_agg (
    .clk_i(clk), .rst_ni(rst_n), .evt1_i(evt1), .evt2_i(evt2),
    .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .throttle_en_i(thr), .irq_o(irq),
    .therm_alarm_o(alarm)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_st1 = 0; m_st2 = 0; m_mk1 = 0; m_mk2 = 0; m_gap = 0;
    end else begin
      if (rd && addr == 0) m_st1 = 0;
      if (rd && addr == 1) m_st2 = 0;
      m_st1 = m_st1 | (evt1 & 8'hDF);
      m_st2 = m_st2 | (evt2 & 8'h99);
      if (wr && addr == 2) m_mk1 = wdata;
      if (wr && addr == 3) m_mk2 = wdata & 8'hF9;
      m_gap = rd && (addr < 2);
    end
  endtask

  task automatic compare(input string tag);
    int exp_rd;
    bit exp_irq, exp_alm;
    case (addr)
      2'd0: exp_rd = m_st1;
      2'd1: exp_rd = m_st2;
      2'd2: exp_rd = m_mk1;
      default: exp_rd = m_mk2;
    endcase
    exp_irq = !m_gap && (((m_st1 & ~m_mk1 & 'hDF) != 0) || ((m_st2 & ~m_mk2 & 'h99) != 0));
    exp_alm = thr && ((m_st1[4] && !m_mk1[5]) || (m_st2[0] && !m_mk2[5]) ||
                      (m_st2[7] && !m_mk2[6]));
    check(tag, "rdata", int'(rdata), exp_rd);
    check(tag, "irq",   int'(irq),   int'(exp_irq));
    check(tag, "alarm", int'(alarm), int'(exp_alm));
  endtask

  task automatic step(input string tag, input logic [7:0] e1, input logic [7:0] e2,
                      input logic [1:0] a, input logic r, input logic w,
                      input logic [7:0] wd, input logic t);
    @(negedge clk);
    evt1 = e1; evt2 = e2; addr = a; rd = r; wr = w; wdata = wd; thr = t;
    @(posedge clk);
    model_edge();
    #1;
    compare(tag);
  endtask

  task automatic idle(input string tag, input logic [1:0] a, input logic t);
    step(tag, 8'h00, 8'h00, a, 1'b0, 1'b0, 8'h00, t);
  endtask

  task automatic wmask(input string tag, input logic [1:0] a, input logic [7:0] d, input logic t);
    step(tag, 8'h00, 8'h00, a, 1'b0, 1'b1, d, t);
  endtask

  task automatic rclr(input string tag, input logic [1:0] a, input logic t);
    step(tag, 8'h00, 8'h00, a, 1'b1, 1'b0, 8'h00, t);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt1 = 0; evt2 = 0; addr = 0; rd = 0; wr = 0; wdata = 0; thr = 0;
    m_st1 = 0; m_st2 = 0; m_mk1 = 0; m_mk2 = 0; m_gap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R5 reset state of all registers
    idle("R5", 2'd2, 1'b0);
    idle("R5", 2'd3, 1'b0);
    idle("R5", 2'd0, 1'b0);
    idle("R5", 2'd1, 1'b0);

    // R1 each word-1 strobe latches; bit 5 is reserved (R2)
    for (int b = 0; b < 8; b++)
      step((b == 5) ? "R2" : "R1", 8'(1 << b), 8'h00, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    rclr("R3", 2'd0, 1'b0);
    idle("R3", 2'd0, 1'b0);

    // R2 word 2 layout and reserved bits
    step("R2", 8'h00, 8'hFF, 2'd1, 1'b0, 1'b0, 8'h00, 1'b0);
    rclr("R3", 2'd1, 1'b0);
    idle("R2", 2'd1, 1'b0);

    // R3 clearing one word leaves the other
    step("R3", 8'h0F, 8'h08, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    rclr("R3", 2'd0, 1'b0);
    idle("R3", 2'd1, 1'b0);
    rclr("R3", 2'd1, 1'b0);
    idle("R3", 2'd0, 1'b0);

    // R4 strobe during clearing read survives
    step("R4", 8'h81, 8'h00, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    step("R4", 8'h40, 8'h00, 2'd0, 1'b1, 1'b0, 8'h00, 1'b0);
    idle("R4", 2'd0, 1'b0);
    step("R4", 8'h00, 8'h10, 2'd1, 1'b1, 1'b0, 8'h00, 1'b0);
    idle("R4", 2'd1, 1'b0);
    rclr("R4", 2'd0, 1'b0);
    rclr("R4", 2'd1, 1'b0);
    idle("R4", 2'd1, 1'b0);

    // R6 mask storage, reserved mask bits, write to status ignored
    wmask("R6", 2'd2, 8'hA5, 1'b0);
    wmask("R6", 2'd3, 8'hFF, 1'b0);
    wmask("R6", 2'd0, 8'h55, 1'b0);
    wmask("R6", 2'd1, 8'hFF, 1'b0);
    idle("R6", 2'd2, 1'b0);
    idle("R6", 2'd3, 1'b0);

    // R5 / R7 mask polarity: m1 = A5 disables bit 0, enables bit 1
    step("R5", 8'h01, 8'h00, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    step("R7", 8'h02, 8'h00, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    wmask("R5", 2'd2, 8'hA7, 1'b0);
    wmask("R7", 2'd2, 8'hA5, 1'b0);
    rclr("R7", 2'd0, 1'b0);
    idle("R7", 2'd0, 1'b0);

    // R8 gap after read, then re-raise
    wmask("R8", 2'd2, 8'h00, 1'b0);
    wmask("R8", 2'd3, 8'h00, 1'b0);
    step("R8", 8'h03, 8'h08, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    rclr("R8", 2'd0, 1'b0);
    idle("R8", 2'd0, 1'b0);
    idle("R8", 2'd1, 1'b0);
    rclr("R8", 2'd1, 1'b0);
    idle("R8", 2'd1, 1'b0);
    step("R8", 8'h0A, 8'h00, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    step("R8", 8'h04, 8'h00, 2'd0, 1'b1, 1'b0, 8'h00, 1'b0);
    idle("R8", 2'd0, 1'b0);
    idle("R8", 2'd0, 1'b0);
    rclr("R8", 2'd0, 1'b0);
    idle("R8", 2'd0, 1'b0);

    // R9 thermal alarm gating and per-sensor alarm masks
    step("R9", 8'h10, 8'h00, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    idle("R9", 2'd0, 1'b1);
    wmask("R9", 2'd2, 8'h20, 1'b1);
    step("R9", 8'h00, 8'h81, 2'd1, 1'b0, 1'b0, 8'h00, 1'b1);
    wmask("R9", 2'd3, 8'h40, 1'b1);
    wmask("R9", 2'd3, 8'h20, 1'b1);
    wmask("R9", 2'd3, 8'h60, 1'b1);
    idle("R9", 2'd3, 1'b0);
    rclr("R9", 2'd0, 1'b1);
    rclr("R9", 2'd1, 1'b1);
    idle("R9", 2'd1, 1'b1);

    // R10 alarm mask bits do not enable the interrupt
    wmask("R10", 2'd2, 8'hDF, 1'b1);
    wmask("R10", 2'd3, 8'h99, 1'b1);
    step("R10", 8'h10, 8'h81, 2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
    idle("R10", 2'd1, 1'b1);
    rclr("R10", 2'd0, 1'b1);
    rclr("R10", 2'd1, 1'b1);
    idle("R10", 2'd3, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule